// File: doc/BRIEF.md
# Glitch-Free Serial Clock Output Gate

This block drives the clock pin of a smart card style serial port. It receives a free-running divided serial clock from a baud generator, which runs in the system clock domain. From that clock it produces the pin clock. Software can start or stop the pin clock at any moment and can choose whether the pin rests low or high while the clock is stopped. The gate acts only on serial clock edges, so the pin never shows a pulse shorter than a normal half period of the serial clock.

When the gating mode is off, the pin simply carries the serial clock. When the mode is on, the pin sits at the chosen rest level until the enable bit is set. The first pin edge after that is a serial clock edge that moves the pin away from the rest level. When the enable bit is cleared, any pulse already on the pin finishes at full width, and the pin then returns to rest. A status output shows whether the pin clock is live.

All four control inputs are registered once before use. A pin change therefore appears two system clock edges after the input that caused it.

Top module: `sclk_park_gate`

## Requirements
- R1: While modeEn is 0, pinClk equals the serClk value sampled two system clock edges earlier, and running is 0.
- R2: While the gate is stopped with modeEn at 1, pinClk holds the rest level (fixLvl 0 means low, 1 means high), taken from fixLvl as sampled two edges earlier. serClk toggles do not reach the pin in this state.
- R3: Setting clkEn to 1 leaves the pin at rest until serClk toggles to the level opposite the rest level. Two edges after that toggle, the pin takes the opposite level.
- R4: While the gate is in mode and fixLvl is unchanged, every pin excursion away from the rest level lasts exactly one serClk half period, including the last pulse after a stop.
- R5: After clkEn is cleared, running falls and the pin is at rest within one serClk period plus three system clocks. The pin then stays at rest.
- R6: running rises on the same edge as the pin's first move away from rest, and falls on an edge where the pin is at rest.
- R7: Synchronous reset (rst high) forces running to 0 and pinClk to the current fixLvl. After reset the gate is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| modeEn | input | 1 | 1 enables gating and parking, 0 passes the serial clock through |
| clkEn | input | 1 | 1 requests a live pin clock, 0 requests a stop |
| fixLvl | input | 1 | Rest level of the pin while stopped |
| serClk | input | 1 | Divided serial clock, changes only on clk edges |
| pinClk | output | 1 | Gated serial clock to the pin |
| running | output | 1 | 1 while the pin clock is live |

## Verification
The assertions assume that serClk is a level signal that changes only between system clock edges. They also assume that fixLvl is not changed while the pin clock is live, because a change there moves the rest level in the middle of a pulse. The stimulus changes fixLvl, the half period and the mode only while the gate is stopped or in pass-through. It changes clkEn at several phases of the serial clock and for both rest levels, so that a stop falls both inside a pulse and inside a rest half.

// File: rtl/sclk_park_pkg.sv
package sclk_park_pkg;

  // Gate state: pin parked at rest level or carrying the serial clock.
  typedef enum logic {
    GATE_PARKED  = 1'b0,
    GATE_RUNNING = 1'b1
  } gateState_t;

  // Strobes from control to datapath choosing the next pin value.
  typedef struct packed {
    logic takeSer;   // load pin from registered serial clock
    logic takePark;  // load pin from registered rest level
  } pinStrb_t;

endpackage

// File: rtl/sclk_park_dp.sv
module sclk_park_dp
  import sclk_park_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     serClk,
  input  logic     fixLvl,
  input  pinStrb_t strb,
  output logic     serNow,
  output logic     serEdge,
  output logic     parkLvl,
  output logic     pinClk
);

  logic serQ;
  logic serPrevQ;
  logic lvlQ;
  logic pinQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      serQ     <= 1'b0;
      serPrevQ <= 1'b0;
      lvlQ     <= fixLvl;
    end else begin
      serQ     <= serClk;
      serPrevQ <= serQ;
      lvlQ     <= fixLvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pinQ <= fixLvl;
    end else if (strb.takeSer) begin
      pinQ <= serQ;
    end else if (strb.takePark) begin
      pinQ <= lvlQ;
    end
  end

  assign serNow  = serQ;
  assign serEdge = serQ ^ serPrevQ;
  assign parkLvl = lvlQ;
  assign pinClk  = pinQ;

endmodule

// File: rtl/sclk_park_ctrl.sv
module sclk_park_ctrl
  import sclk_park_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     modeEn,
  input  logic     clkEn,
  input  logic     serNow,
  input  logic     serEdge,
  input  logic     parkLvl,
  output pinStrb_t strb,
  output logic     running
);

  logic       modeQ;
  logic       enQ;
  gateState_t stateQ;
  gateState_t stateNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= 1'b1;
      enQ   <= 1'b0;
    end else begin
      modeQ <= modeEn;
      enQ   <= clkEn;
    end
  end

  // Start on a serial edge that leaves the rest level; stop once the serial
  // clock sits at the rest level, so the pulse in progress completes.
  always_comb begin
    stateNext     = stateQ;
    strb.takeSer  = 1'b0;
    strb.takePark = 1'b0;
    if (!modeQ) begin
      stateNext    = GATE_PARKED;
      strb.takeSer = 1'b1;
    end else if (stateQ == GATE_RUNNING) begin
      strb.takeSer = 1'b1;
      if (!enQ && (serNow == parkLvl)) begin
        stateNext = GATE_PARKED;
      end
    end else if (enQ && serEdge && (serNow != parkLvl)) begin
      stateNext    = GATE_RUNNING;
      strb.takeSer = 1'b1;
    end else begin
      strb.takePark = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= GATE_PARKED;
    end else begin
      stateQ <= stateNext;
    end
  end

  assign running = (stateQ == GATE_RUNNING);

endmodule

// File: rtl/sclk_park_gate.sv
module sclk_park_gate
  import sclk_park_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic modeEn,
  input  logic clkEn,
  input  logic fixLvl,
  input  logic serClk,
  output logic pinClk,
  output logic running
);

  pinStrb_t strb;
  logic     serNow;
  logic     serEdge;
  logic     parkLvl;

  sclk_park_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .modeEn  (modeEn),
    .clkEn   (clkEn),
    .serNow  (serNow),
    .serEdge (serEdge),
    .parkLvl (parkLvl),
    .strb    (strb),
    .running (running)
  );

  sclk_park_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .serClk  (serClk),
    .fixLvl  (fixLvl),
    .strb    (strb),
    .serNow  (serNow),
    .serEdge (serEdge),
    .parkLvl (parkLvl),
    .pinClk  (pinClk)
  );

endmodule

// File: rtl/sclk_park_gate_chk.sv
module sclk_park_gate_chk (
  input logic clk,
  input logic rst,
  input logic modeEn,
  input logic clkEn,
  input logic fixLvl,
  input logic serClk,
  input logic pinClk,
  input logic running
);

  // Edges since reset, saturating, so that $past never reaches before reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r1_pass_through: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$past(modeEn, 2)) |-> (pinClk == $past(serClk, 2)));

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$past(modeEn, 2)) |-> !running);

  a_r2_park_level: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(modeEn, 2) && !running) |-> (pinClk == $past(fixLvl, 2)));

  a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $rose(running)) |-> $past(clkEn, 2));

  a_r4_live_follows_serial: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(modeEn, 2) && running) |-> (pinClk == $past(serClk, 2)));

  a_r5_stop_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(modeEn, 2) && $fell(running)) |-> !$past(clkEn, 2));

  a_r6_rise_leaves_rest: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $rose(running)) |-> (pinClk != $past(fixLvl, 2)));

endmodule

bind sclk_park_gate sclk_park_gate_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .modeEn  (modeEn),
  .clkEn   (clkEn),
  .fixLvl  (fixLvl),
  .serClk  (serClk),
  .pinClk  (pinClk),
  .running (running)
);

// File: tb/test_sclk_park_gate.sv
module test_sclk_park_gate;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeEn = 1'b1;
  logic clkEn = 1'b0;
  logic fixLvl = 1'b1;
  logic serClk = 1'b0;
  logic pinClk;
  logic running;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int halfPer = 4;
  int serCnt = 0;
  bit monOn = 0;
  int awayLen = 0;
  string curReq = "R7";

  // Behavioural reference state
  int mS = 0, mSp = 0, mE = 0, mM = 1, mL = 1, mPin = 1, mRun = 0;

  sclk_park_gate i_sclk_park_gate (
    .clk     (clk),
    .rst     (rst),
    .modeEn  (modeEn),
    .clkEn   (clkEn),
    .fixLvl  (fixLvl),
    .serClk  (serClk),
    .pinClk  (pinClk),
    .running (running)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    int nPin, nRun;
    if (rst) begin
      mS = 0; mSp = 0; mE = 0; mM = 1; mL = int'(fixLvl); mPin = int'(fixLvl); mRun = 0;
    end else begin
      if (mM == 0) begin
        nRun = 0; nPin = mS;
      end else if (mRun == 1) begin
        nPin = mS;
        nRun = (mE == 0 && mS == mL) ? 0 : 1;
      end else if (mE == 1 && mS != mSp && mS != mL) begin
        nRun = 1; nPin = mS;
      end else begin
        nRun = 0; nPin = mL;
      end
      mSp = mS; mS = int'(serClk); mE = int'(clkEn); mM = int'(modeEn); mL = int'(fixLvl);
      mPin = nPin; mRun = nRun;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(curReq, pinClk === 1'(mPin), int'(pinClk), mPin, "pinClk vs model");
    check(curReq, running === 1'(mRun), int'(running), mRun, "running vs model");
    if (monOn) begin
      if (pinClk != fixLvl) awayLen++;
      else if (awayLen > 0) begin
        check("R4", awayLen == halfPer, awayLen, halfPer, "pulse width");
        awayLen = 0;
      end
    end
    serCnt++;
    if (serCnt >= halfPer) begin
      serCnt = 0;
      serClk = ~serClk;
    end
  endtask

  task automatic runStartStop(input int lvl, input int hp, input int liveTicks);
    int n;
    bit found;
    fixLvl = 1'(lvl); halfPer = hp; clkEn = 1'b0;
    curReq = "R2";
    repeat (4) tick();
    check("R2", pinClk == fixLvl, int'(pinClk), lvl, "rest level before start");
    monOn = 1; awayLen = 0;
    curReq = "R3";
    clkEn = 1'b1;
    found = 0;
    for (int i = 0; i < 4 * hp + 4; i++) begin
      tick();
      if (pinClk != fixLvl) begin found = 1; break; end
    end
    check("R3", found, int'(found), 1, "pin leaves rest after start");
    check("R6", running == 1'b1, int'(running), 1, "running with first pulse");
    curReq = "R4";
    repeat (liveTicks) tick();
    curReq = "R5";
    clkEn = 1'b0;
    n = 0;
    while (running && n < 4 * hp + 8) begin tick(); n++; end
    check("R5", n <= 2 * hp + 3, n, 2 * hp + 3, "ticks until stopped");
    check("R6", pinClk == fixLvl, int'(pinClk), lvl, "pin at rest when running falls");
    repeat (3 * hp) tick();
    check("R5", pinClk == fixLvl && !running, int'(pinClk), lvl, "pin stays at rest");
    monOn = 0;
  endtask

  initial begin
    int toggles;
    logic lastPin;
    repeat (3) tick();
    check("R7", pinClk == 1'b1 && running == 1'b0, int'(pinClk), 1, "pin in reset");
    rst = 1'b0;
    tick();
    check("R7", pinClk == 1'b1 && running == 1'b0, int'(pinClk), 1, "stopped after reset");

    // Pass-through
    curReq = "R1";
    modeEn = 1'b0;
    toggles = 0;
    lastPin = pinClk;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (pinClk != lastPin) toggles++;
      lastPin = pinClk;
    end
    check("R1", toggles >= 6, toggles, 6, "pass-through toggles");
    check("R1", running == 1'b0, int'(running), 0, "running off in pass-through");

    // Parked, level change while stopped
    curReq = "R2";
    modeEn = 1'b1; fixLvl = 1'b0;
    repeat (4) tick();
    check("R2", pinClk == 1'b0, int'(pinClk), 0, "parked low");
    fixLvl = 1'b1;
    tick();
    check("R2", pinClk == 1'b0, int'(pinClk), 0, "level not yet applied");
    tick();
    check("R2", pinClk == 1'b1, int'(pinClk), 1, "level applied after two edges");
    toggles = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (pinClk != 1'b1) toggles++;
    end
    check("R2", toggles == 0, toggles, 0, "serial ignored while parked");

    // Start/stop at many phases and both rest levels
    for (int off = 0; off < 6; off++) begin
      runStartStop(0, 4, 12 + off);
      runStartStop(1, 3, 9 + off);
    end
    runStartStop(0, 5, 23);

    // Reset during a live clock
    curReq = "R7";
    fixLvl = 1'b1; halfPer = 3; clkEn = 1'b1;
    repeat (20) tick();
    rst = 1'b1;
    tick();
    check("R7", pinClk == 1'b1 && running == 1'b0, int'(pinClk), 1, "reset mid-run");
    rst = 1'b0; clkEn = 1'b0;
    repeat (10) tick();
    check("R7", running == 1'b0, int'(running), 0, "stopped after mid-run reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule